// File: doc/BRIEF.md
# Four-Phase Instruction Clock Controller

This block sequences a slow multi-phase machine one instruction at a time. Each instruction is split into four equal phases, and each phase lasts a fixed number of base ticks. The first and third phases each carry a pair of strobes: a wide activate strobe and a clear strobe nested inside it. The second and fourth phases carry no strobes. They give the state set in the phase before them time to settle before the next strobe pair fires. The third-phase pair loads the operand latches, and the first-phase pair of the next instruction writes the result back.

A user can start the sequence for continuous execution, stop it, or advance it by exactly one instruction per single-step press. Stop requests, and halt requests from the instruction decoder, are held until the current instruction has finished its fourth phase, so an instruction is never cut off midway. A one-cycle boundary pulse marks each completed instruction, and a busy level shows whether the sequence is running.

Top module: `quad_phase_clkctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four strobes, `busy` and `instr_done` are low.
- R2: Every phase lasts exactly PHASE_TICKS base ticks. With a tick every s clock cycles, a third-phase activate strobe stays high for PHASE_TICKS*s cycles.
- R3: A clear strobe is never high while its activate strobe is low. It rises one tick period after its activate rises and falls one tick period before its activate falls, so with a tick every s cycles it is high for (PHASE_TICKS-2)*s cycles.
- R4: The phases run in a fixed order: phase 1 (`ph1_act`/`ph1_clr`), phase 2 with no strobes, phase 3 (`ph3_act`/`ph3_clr`), and phase 4 with no strobes. The fall of `ph1_act` and the rise of `ph3_act` are PHASE_TICKS tick periods apart, and the two activate strobes are never high together.
- R5: A run request while idle starts continuous execution. Instructions follow each other with no gap, so `ph1_act` is already high in the cycle in which `instr_done` reports the previous instruction.
- R6: A rising edge of `step_req` while idle runs exactly one instruction and then returns to idle. Every later rising edge runs one more instruction.
- R7: Holding `step_req` high for many instructions' worth of cycles runs only one instruction.
- R8: A stop request takes effect only at the end of phase 4. `busy` stays high until then, and it falls in the same cycle in which `instr_done` pulses for that instruction.
- R9: A halt request stops execution at the end of the current instruction, in the same way as a stop request. A later step or run request resumes execution.
- R10: `instr_done` is a one-cycle pulse, given once per completed instruction, in the clock cycle after the last tick of phase 4.
- R11: While idle, a stop request blocks a run or step request given in the same cycle. A run request takes priority over a step request given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base tick enable; each phase counts these |
| run_req | input | 1 | Start continuous execution (taken when idle) |
| stop_req | input | 1 | Stop at the next instruction boundary |
| step_req | input | 1 | Single-step button level (edge detected) |
| halt_req | input | 1 | Halt from the decoder; stops at the boundary |
| ph1_act | output | 1 | Phase-1 activate strobe |
| ph1_clr | output | 1 | Phase-1 clear strobe, nested in ph1_act |
| ph3_act | output | 1 | Phase-3 activate strobe |
| ph3_clr | output | 1 | Phase-3 clear strobe, nested in ph3_act |
| busy | output | 1 | High while an instruction is in progress |
| instr_done | output | 1 | One-cycle pulse per completed instruction |

## Verification
The hardest case to reach is the relation between tick spacing and strobe nesting. The clear margins and phase widths are set in ticks, not in clock cycles, so an error in counting ticks only shows when ticks are sparse. The stimulus therefore sweeps the tick period from one to four clock cycles and measures the third-phase strobes in cycles, because that pair is never affected by where the divider happened to be when the instruction started. Stop and halt requests are placed a few cycles after an observed boundary, which puts them in the middle of an instruction. This shows that the stop is deferred to the boundary rather than lost or applied at once.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;

  typedef enum logic [1:0] {
    PH1 = 2'd0,
    PH2 = 2'd1,
    PH3 = 2'd2,
    PH4 = 2'd3
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH1:     return PH2;
      PH2:     return PH3;
      PH3:     return PH4;
      default: return PH1;
    endcase
  endfunction

  // last tick slot of a phase of length len
  function automatic bit at_phase_end(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // clear window: one slot after the first, one slot before the last
  function automatic bit in_clear_window(input int unsigned cnt, input int unsigned len);
    return (cnt >= 1) && (cnt + 2 <= len);
  endfunction

endpackage

// File: rtl/qpc_rise_det.sv
`timescale 1ns/1ps
module qpc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;

  // R7: a held level produces one edge only
  a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/qpc_phase_seq.sv
`timescale 1ns/1ps
module qpc_phase_seq #(
  parameter int unsigned PHASE_TICKS = 4,
  parameter int unsigned CNT_W       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               tick,
  output qpc_pkg::phase_e    phase,
  output logic [CNT_W-1:0]   cnt,
  output logic               boundary
);
  import qpc_pkg::*;

  logic slot_last;
  logic adv;

  assign slot_last = at_phase_end(int'(cnt), PHASE_TICKS);
  assign adv       = active & tick;
  assign boundary  = adv & slot_last & (phase == PH4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH1;
      cnt   <= '0;
    end else if (!active) begin
      phase <= PH1;
      cnt   <= '0;
    end else if (tick) begin
      if (slot_last) begin
        cnt   <= '0;
        phase <= next_phase(phase);
      end else begin
        cnt   <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: nothing moves between ticks
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(tick)) |-> ($stable(cnt) && $stable(phase)));

  // R4: phases only step forward by one
  a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && (phase != $past(phase))) |-> (phase == next_phase($past(phase))));

endmodule

// File: rtl/qpc_strobe_gen.sv
`timescale 1ns/1ps
module qpc_strobe_gen #(
  parameter int unsigned PHASE_TICKS = 4,
  parameter int unsigned CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  qpc_pkg::phase_e  phase,
  input  logic [CNT_W-1:0] cnt,
  output logic [1:0]       act,
  output logic [1:0]       clr
);
  import qpc_pkg::*;

  for (genvar g = 0; g < 2; g++) begin : g_pair
    localparam phase_e OWN_PH = (g == 0) ? PH1 : PH3;

    assign act[g] = busy & (phase == OWN_PH);
    assign clr[g] = act[g] & in_clear_window(int'(cnt), PHASE_TICKS);

    // R3: clear starts only after activate is already up
    a_r3_clr_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr[g]) |-> $past(act[g]));

    // R3: clear is already down when activate drops
    a_r3_act_outlasts_clr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act[g]) |-> !$past(clr[g]));
  end

  // R4: the two activate strobes never overlap
  a_r4_one_act: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

endmodule

// File: rtl/qpc_run_ctl.sv
`timescale 1ns/1ps
module qpc_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic stop_req,
  input  logic halt_req,
  input  logic step_edge,
  input  logic boundary,
  output logic busy,
  output logic instr_done
);
  logic cont;
  logic stop_pend;
  logic start_run;
  logic start_step;
  logic end_now;

  assign start_run  = ~busy & run_req & ~stop_req;
  assign start_step = ~busy & step_edge & ~run_req & ~stop_req;
  assign end_now    = boundary & (~cont | stop_pend | stop_req | halt_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cont       <= 1'b0;
      stop_pend  <= 1'b0;
      instr_done <= 1'b0;
    end else begin
      instr_done <= boundary;
      if (!busy) begin
        stop_pend <= 1'b0;
        if (start_run) begin
          busy <= 1'b1;
          cont <= 1'b1;
        end else if (start_step) begin
          busy <= 1'b1;
          cont <= 1'b0;
        end
      end else if (end_now) begin
        busy      <= 1'b0;
        cont      <= 1'b0;
        stop_pend <= 1'b0;
      end else if (stop_req | halt_req) begin
        stop_pend <= 1'b1;
      end
    end
  end

  // R8: execution only ever ends at an instruction boundary
  a_r8_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(boundary));

  // R6: a single step ends at its first boundary
  a_r6_step_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cont && boundary) |=> !busy);

  // R10: the boundary pulse is one cycle wide
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  // R11: stop while idle blocks any start
  a_r11_stop_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_req) |=> !busy);

endmodule

// File: rtl/quad_phase_clkctl.sv
`timescale 1ns/1ps
module quad_phase_clkctl #(
  parameter int unsigned PHASE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_req,
  input  logic stop_req,
  input  logic step_req,
  input  logic halt_req,
  output logic ph1_act,
  output logic ph1_clr,
  output logic ph3_act,
  output logic ph3_clr,
  output logic busy,
  output logic instr_done
);
  localparam int unsigned CNT_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;

  qpc_pkg::phase_e  phase;
  logic [CNT_W-1:0] cnt;
  logic             boundary;
  logic             step_edge;
  logic [1:0]       act;
  logic [1:0]       clr;

  qpc_rise_det u_step_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (step_req),
    .rise  (step_edge)
  );

  qpc_run_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .stop_req   (stop_req),
    .halt_req   (halt_req),
    .step_edge  (step_edge),
    .boundary   (boundary),
    .busy       (busy),
    .instr_done (instr_done)
  );

  qpc_phase_seq #(.PHASE_TICKS(PHASE_TICKS), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .tick     (tick),
    .phase    (phase),
    .cnt      (cnt),
    .boundary (boundary)
  );

  qpc_strobe_gen #(.PHASE_TICKS(PHASE_TICKS), .CNT_W(CNT_W)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .phase (phase),
    .cnt   (cnt),
    .act   (act),
    .clr   (clr)
  );

  assign ph1_act = act[0];
  assign ph1_clr = clr[0];
  assign ph3_act = act[1];
  assign ph3_clr = clr[1];

  // R1: nothing is driven right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !instr_done));

  // R10: each boundary pulse follows a cycle in which the machine was busy
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $past(busy));

endmodule

// File: tb/quad_phase_clkctl_bench.sv
`timescale 1ns/1ps
module quad_phase_clkctl_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic run_req = 1'b0, stop_req = 1'b0, step_req = 1'b0, halt_req = 1'b0;
  logic ph1_act, ph1_clr, ph3_act, ph3_clr, busy, instr_done;

  always #2.5 clk = ~clk;

  quad_phase_clkctl #(.PHASE_TICKS(N)) u_quad_phase_clkctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(run_req), .stop_req(stop_req),
    .step_req(step_req), .halt_req(halt_req), .ph1_act(ph1_act), .ph1_clr(ph1_clr),
    .ph3_act(ph3_act), .ph3_clr(ph3_clr), .busy(busy), .instr_done(instr_done)
  );

  int checks = 0, failures = 0;
  int cycle = 0, divc = 0, sdiv = 1;
  int done_cnt = 0, nest_viol = 0, pulse_viol = 0;
  int t_p3a_r = 0, t_p3a_f = 0, t_p3c_r = 0, t_p3c_f = 0, t_p1a_f = 0;
  logic pv_p1a = 0, pv_p3a = 0, pv_p3c = 0, pv_done = 0;
  logic busy_at_done = 0, p1a_at_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycle++;
    if ((ph1_clr && !ph1_act) || (ph3_clr && !ph3_act) || (ph1_act && ph3_act)) nest_viol++;
    if (ph3_act && !pv_p3a) t_p3a_r = cycle;
    if (!ph3_act && pv_p3a) t_p3a_f = cycle;
    if (ph3_clr && !pv_p3c) t_p3c_r = cycle;
    if (!ph3_clr && pv_p3c) t_p3c_f = cycle;
    if (!ph1_act && pv_p1a) t_p1a_f = cycle;
    if (instr_done) begin
      done_cnt++;
      busy_at_done = busy;
      p1a_at_done = ph1_act;
      if (pv_done) pulse_viol++;
    end
    pv_p1a = ph1_act; pv_p3a = ph3_act; pv_p3c = ph3_clr; pv_done = instr_done;
    divc = (divc + 1 >= sdiv) ? 0 : divc + 1;
    tick = (divc == 0);
    if (cycle > 100000) begin
      chk(1'b0, "watchdog", cycle, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wait_done();
    int start = done_cnt;
    for (int i = 0; i < 2000; i++) begin
      cyc();
      if (done_cnt > start) break;
    end
  endtask

  task automatic pulse_step();
    step_req = 1'b1; cyc(); step_req = 1'b0;
  endtask

  initial begin
    int d0;
    repeat (3) cyc();
    chk(!ph1_act && !ph1_clr && !ph3_act && !ph3_clr && !busy && !instr_done, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    cyc();
    chk(!ph1_act && !ph3_act && !busy && !instr_done, "R1 after reset", busy, 0);

    // sweep the tick period: R2 R3 R4 R6 R10
    for (int s = 1; s <= 4; s++) begin
      sdiv = s;
      for (int rep = 0; rep < 2; rep++) begin
        d0 = done_cnt;
        pulse_step();
        wait_done();
        repeat (3) cyc();
        chk(t_p3a_f - t_p3a_r == N * s, "R2 ph3 activate width", t_p3a_f - t_p3a_r, N * s);
        chk(t_p3c_f - t_p3c_r == (N - 2) * s, "R3 ph3 clear width", t_p3c_f - t_p3c_r, (N - 2) * s);
        chk(t_p3c_r - t_p3a_r == s, "R3 clear rise lag", t_p3c_r - t_p3a_r, s);
        chk(t_p3a_f - t_p3c_f == s, "R3 clear fall lead", t_p3a_f - t_p3c_f, s);
        chk(t_p3a_r - t_p1a_f == N * s, "R4 phase2 settle gap", t_p3a_r - t_p1a_f, N * s);
        chk(done_cnt == d0 + 1, "R6 R10 one done per step", done_cnt - d0, 1);
        chk(!busy && !busy_at_done, "R6 idle after step", busy, 0);
      end
    end

    // R7: held step button
    sdiv = 1;
    d0 = done_cnt;
    step_req = 1'b1;
    repeat (12 * N) cyc();
    step_req = 1'b0;
    repeat (4) cyc();
    chk(done_cnt == d0 + 1, "R7 held step runs one", done_cnt - d0, 1);
    chk(!busy, "R7 idle after held step", busy, 0);

    // R5 / R8: continuous run and deferred stop
    run_req = 1'b1; cyc(); run_req = 1'b0;
    d0 = done_cnt;
    wait_done();
    chk(busy_at_done && p1a_at_done, "R5 back-to-back instructions", p1a_at_done, 1);
    wait_done();
    chk(done_cnt == d0 + 2 && busy, "R5 continuous run", done_cnt - d0, 2);
    repeat (5) cyc();
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    cyc();
    chk(busy, "R8 busy held after stop", busy, 1);
    d0 = done_cnt;
    wait_done();
    chk(!busy_at_done, "R8 busy falls with done", busy_at_done, 0);
    repeat (6 * N) cyc();
    chk(done_cnt == d0 + 1 && !busy && !ph1_act, "R8 stopped at boundary", done_cnt - d0, 1);

    // R9: halt then resume by step
    run_req = 1'b1; cyc(); run_req = 1'b0;
    wait_done();
    repeat (3) cyc();
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    d0 = done_cnt;
    wait_done();
    repeat (6 * N) cyc();
    chk(done_cnt == d0 + 1 && !busy, "R9 halt stops at boundary", done_cnt - d0, 1);
    d0 = done_cnt;
    pulse_step();
    wait_done();
    repeat (3) cyc();
    chk(done_cnt == d0 + 1 && !busy, "R9 step resumes after halt", done_cnt - d0, 1);

    // R11: stop blocks start; run beats step
    d0 = done_cnt;
    run_req = 1'b1; stop_req = 1'b1; cyc(); run_req = 1'b0; stop_req = 1'b0;
    repeat (8 * N) cyc();
    chk(!busy && done_cnt == d0, "R11 stop blocks run", done_cnt - d0, 0);
    step_req = 1'b1; stop_req = 1'b1; cyc(); step_req = 1'b0; stop_req = 1'b0;
    repeat (8 * N) cyc();
    chk(!busy && done_cnt == d0, "R11 stop blocks step", done_cnt - d0, 0);
    run_req = 1'b1; step_req = 1'b1; cyc(); run_req = 1'b0; step_req = 1'b0;
    repeat (12 * N) cyc();
    chk(busy && done_cnt >= d0 + 2, "R11 run beats step", done_cnt - d0, 2);
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    wait_done();
    repeat (3) cyc();
    chk(!busy, "R11 stopped afterwards", busy, 0);

    chk(nest_viol == 0, "R3 R4 nesting over whole run", nest_viol, 0);
    chk(pulse_viol == 0, "R10 done pulse width", pulse_viol, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule